// File: doc/BRIEF.md
# Pseudo-Random Sequence Receive Checker with Automatic Synchronisation

The block takes a recovered serial bit stream, one bit per accepted transfer, and locks a local reference generator to a selected maximal-length pseudo-random sequence. Acquisition fills the reference register from the received bits. It then requires an unbroken run of matching, or of uniformly mismatching, bits before it declares lock. The second case means the data arrived inverted, and the comparison is flipped from then on. Once locked, the reference runs free and each received bit is compared with it.

While a test runs, the block counts locked bits, bit errors, errored seconds (from a one-second tick supplied by an external prescaler) and bit slips. A slip is a loss of lock, caused by too many errors inside a 1024-bit evaluation window, that is followed by reacquisition. The test ends on its own once the bit counter reaches the programmed length. A small register port selects the sequence, its direction, the resync threshold and the test length, and returns the counters and status.

The stream input is valid/ready. `s_ready` is held high at all times because the checker consumes one bit per cycle and never applies back-pressure. A bit is taken on every rising clock edge at which `s_valid` is high. When `s_valid` is low, `s_data` is ignored.

Top module: `prbs_rx_checker`

## Requirements
- R1: Writing address 0 sets `{threshold[15:6], sel[5:2], reverse[1], run[0]}`. A write with run=1 clears all counters and restarts acquisition. For sel 0..10 the forward sequence obeys b[t] = XOR of b[t-k] over the tap set, which is {5,3}, {7,6}, {9,5}, {11,9}, {15,14}, {17,14}, {19,18,17,14}, {20,17}, {23,18}, {25,22} and {31,28} respectively. A clean locked stream yields zero errors, and address 4 (bits [31:0]) and address 5 (bits [39:32]) read the number of locked bits.
- R2: With reverse=1, every tap k other than the order n is replaced by n-k (the reciprocal polynomial), and such a stream locks error-free.
- R3: sel 11 uses the user tap mask held at address 1: bit k-1 set means tap k, and the order is the highest set bit plus one.
- R4: After a restart, lock (status at address 10, bit 0) is declared on exactly the 3n-th accepted bit: n bits seed the reference, then 2n consecutive consistent bits follow.
- R5: An inverted stream locks with status bit 1 set and counts no errors.
- R6: While locked and running, each mismatching bit adds one to the error counter (address 6 low, address 7 high). Bits taken during acquisition are not counted.
- R7: Lock is dropped on the locked bit that brings the error count within the current 1024-bit window up to the threshold (a threshold of 0 is treated as 1). The error count restarts at every window boundary.
- R8: Each loss of lock followed by reacquisition during a running test adds one to the slip counter (address 9).
- R9: On each `sec_tick`, the errored-seconds counter (address 8) increments if at least one error was counted since the previous tick.
- R10: When the locked-bit count reaches the length at addresses 2 (low) and 3 (bits [39:32]), status bit 2 (done) sets, status bit 3 (running) clears, and counting stops. A length of 0 means no limit.
- R11: `s_ready` is always high, and cycles with `s_valid` low change no counter or lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Received bit valid |
| s_data | input | 1 | Received bit |
| s_ready | output | 1 | Always high |
| sec_tick | input | 1 | One-cycle pulse each second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The hardest state to reach from the ports is a bit slip. It needs lock, then a precisely counted burst of errors landing inside one evaluation window, then a clean stretch long enough for reacquisition. The bench keeps its own copy of the sequence running through every injected error, so it knows exactly which bit tips the threshold and how many bits relock takes. Window expiry is reached by separating two errors by more than 1024 clean bits under a threshold of two.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  localparam int LFSR_W = 31;

  typedef enum logic [1:0] {SYNC_SEED, SYNC_HUNT, SYNC_LOCK} sync_st_e;

  function automatic logic [LFSR_W-1:0] pair_mask(input int n, input int k);
    return (LFSR_W'(1) << (n - 1)) | (LFSR_W'(1) << (k - 1));
  endfunction

  function automatic logic [LFSR_W-1:0] tap_mask(input logic [3:0] sel, input logic rev,
                                                   input logic [LFSR_W-1:0] user);
    logic [LFSR_W-1:0] m;
    case (sel)
      4'd0:  m = rev ? pair_mask(5, 2)   : pair_mask(5, 3);
      4'd1:  m = rev ? pair_mask(7, 1)   : pair_mask(7, 6);
      4'd2:  m = rev ? pair_mask(9, 4)   : pair_mask(9, 5);
      4'd3:  m = rev ? pair_mask(11, 2)  : pair_mask(11, 9);
      4'd4:  m = rev ? pair_mask(15, 1)  : pair_mask(15, 14);
      4'd5:  m = rev ? pair_mask(17, 3)  : pair_mask(17, 14);
      4'd6:  m = rev ? (pair_mask(19, 1) | pair_mask(2, 5))
                     : (pair_mask(19, 18) | pair_mask(17, 14));
      4'd7:  m = rev ? pair_mask(20, 3)  : pair_mask(20, 17);
      4'd8:  m = rev ? pair_mask(23, 5)  : pair_mask(23, 18);
      4'd9:  m = rev ? pair_mask(25, 3)  : pair_mask(25, 22);
      4'd10: m = rev ? pair_mask(31, 3)  : pair_mask(31, 28);
      default: m = user;
    endcase
    return m;
  endfunction

  function automatic logic [4:0] poly_order(input logic [3:0] sel, input logic [LFSR_W-1:0] user);
    logic [4:0] n;
    case (sel)
      4'd0: n = 5'd5;   4'd1: n = 5'd7;   4'd2: n = 5'd9;   4'd3: n = 5'd11;
      4'd4: n = 5'd15;  4'd5: n = 5'd17;  4'd6: n = 5'd19;  4'd7: n = 5'd20;
      4'd8: n = 5'd23;  4'd9: n = 5'd25;  4'd10: n = 5'd31;
      default: begin
        n = 5'd1;
        for (int i = 0; i < LFSR_W; i++) if (user[i]) n = 5'(i + 1);
      end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              complement,
  input  logic [LFSR_W-1:0] mask,
  output logic              pred
);
  logic [LFSR_W-1:0] hist_q, hist_nxt;

  // hist_q[k-1] holds the bit taken k steps ago
  assign pred = ^(hist_q & mask);

  always_comb begin
    hist_nxt = shift_en ? {hist_q[LFSR_W-2:0], shift_bit} : hist_q;
    if (complement) hist_nxt = ~hist_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end
endmodule

// File: rtl/prbs_sync_fsm.sv
module prbs_sync_fsm
  import prbs_chk_pkg::*;
#(
  parameter int WIN_LOG2 = 10,
  parameter int THR_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             pred,
  input  logic [4:0]       order,
  input  logic [THR_W-1:0] thr,
  output logic             shift_bit,
  output logic             complement,
  output logic             lock_o,
  output logic             inv_o,
  output logic             chk_valid,
  output logic             chk_err,
  output logic             loss_o,
  output logic             relock_o
);
  localparam int RUN_W = 7;

  sync_st_e           st_q, st_d;
  logic [RUN_W-1:0]   cnt_q, cnt_d;
  logic               mode_q, mode_d, inv_q, inv_d;
  logic [WIN_LOG2-1:0] win_cnt_q, win_cnt_d;
  logic [THR_W-1:0]   win_err_q, win_err_d;
  logic [THR_W-1:0]   thr_eff;
  logic               mism;
  logic [RUN_W-1:0]   need_run;

  assign thr_eff  = (thr == '0) ? THR_W'(1) : thr;
  assign mism     = in_bit ^ pred;
  assign need_run = RUN_W'({order, 1'b0});
  assign lock_o   = (st_q == SYNC_LOCK);
  assign inv_o    = inv_q;
  assign shift_bit = (st_q == SYNC_LOCK) ? pred : in_bit;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; mode_d = mode_q; inv_d = inv_q;
    win_cnt_d = win_cnt_q; win_err_d = win_err_q;
    complement = 1'b0; chk_valid = 1'b0; chk_err = 1'b0;
    loss_o = 1'b0; relock_o = 1'b0;
    if (restart) begin
      st_d = SYNC_SEED; cnt_d = '0; inv_d = 1'b0;
    end else if (in_valid) begin
      case (st_q)
        SYNC_SEED: begin
          if (cnt_q == RUN_W'(order) - RUN_W'(1)) begin
            st_d = SYNC_HUNT; cnt_d = '0;
          end else cnt_d = cnt_q + RUN_W'(1);
        end
        SYNC_HUNT: begin
          cnt_d  = (cnt_q == '0 || mism == mode_q) ? cnt_q + RUN_W'(1) : RUN_W'(1);
          mode_d = mism;
          if (cnt_d == need_run) begin
            st_d = SYNC_LOCK; inv_d = mism; complement = mism;
            relock_o = 1'b1; win_cnt_d = '0; win_err_d = '0;
          end
        end
        default: begin
          chk_valid = 1'b1;
          chk_err   = in_bit ^ inv_q ^ pred;
          win_err_d = win_err_q + THR_W'(chk_err);
          win_cnt_d = win_cnt_q + WIN_LOG2'(1);
          if (win_err_d >= thr_eff) begin
            loss_o = 1'b1; st_d = SYNC_SEED; cnt_d = '0; inv_d = 1'b0;
          end else if (win_cnt_q == '1) win_err_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SYNC_SEED; cnt_q <= '0; mode_q <= 1'b0; inv_q <= 1'b0;
      win_cnt_q <= '0; win_err_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; mode_q <= mode_d; inv_q <= inv_d;
      win_cnt_q <= win_cnt_d; win_err_q <= win_err_d;
    end
  end

  // R5
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && $past(lock_o)) |-> $stable(inv_q));
  // R7
  loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_o |=> !lock_o);
endmodule

// File: rtl/prbs_meas_counters.sv
module prbs_meas_counters #(
  parameter int CNT_W  = 40,
  parameter int ESEC_W = 32,
  parameter int SLIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CNT_W-1:0]  len,
  input  logic              chk_valid,
  input  logic              chk_err,
  input  logic              sec_tick,
  input  logic              loss,
  input  logic              relock,
  output logic [CNT_W-1:0]  bits_o,
  output logic [CNT_W-1:0]  errs_o,
  output logic [ESEC_W-1:0] esec_o,
  output logic [SLIP_W-1:0] slips_o,
  output logic              running_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  bits_q, errs_q;
  logic [ESEC_W-1:0] esec_q;
  logic [SLIP_W-1:0] slips_q;
  logic running_q, done_q, lost_q, sec_err_q;
  logic bit_ev, err_hit, reach;

  assign bit_ev  = running_q && chk_valid && (bits_q != '1);
  assign err_hit = bit_ev && chk_err;
  assign reach   = bit_ev && (len != '0) && (bits_q + CNT_W'(1) == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0; errs_q <= '0; esec_q <= '0; slips_q <= '0;
      running_q <= 1'b0; done_q <= 1'b0; lost_q <= 1'b0; sec_err_q <= 1'b0;
    end else if (start) begin
      bits_q <= '0; errs_q <= '0; esec_q <= '0; slips_q <= '0;
      running_q <= 1'b1; done_q <= 1'b0; lost_q <= 1'b0; sec_err_q <= 1'b0;
    end else begin
      if (stop) running_q <= 1'b0;
      if (bit_ev) bits_q <= bits_q + CNT_W'(1);
      if (err_hit) errs_q <= errs_q + CNT_W'(1);
      if (reach) begin
        running_q <= 1'b0; done_q <= 1'b1;
      end
      if (sec_tick) begin
        if ((sec_err_q || err_hit) && esec_q != '1) esec_q <= esec_q + ESEC_W'(1);
        sec_err_q <= 1'b0;
      end else if (err_hit) sec_err_q <= 1'b1;
      if (running_q && loss) lost_q <= 1'b1;
      else if (running_q && relock && lost_q) begin
        lost_q <= 1'b0;
        if (slips_q != '1) slips_q <= slips_q + SLIP_W'(1);
      end
    end
  end

  assign bits_o = bits_q; assign errs_o = errs_q; assign esec_o = esec_q;
  assign slips_o = slips_q; assign running_o = running_q; assign done_o = done_q;

  // R1
  bits_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (bits_q >= $past(bits_q)));
  // R6
  err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errs_q <= bits_q);
  // R8
  slip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((slips_q - $past(slips_q)) <= SLIP_W'(1)));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !running_q);
endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
  import prbs_chk_pkg::*;
#(
  parameter int CNT_W    = 40,
  parameter int ESEC_W   = 32,
  parameter int SLIP_W   = 16,
  parameter int WIN_LOG2 = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_data,
  output logic        s_ready,
  input  logic        sec_tick,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int THR_W = WIN_LOG2;

  logic [15:0]       ctrl_q;
  logic [LFSR_W-1:0] user_q;
  logic [63:0]       len_q;
  logic              start, stop;
  logic [LFSR_W-1:0] mask;
  logic [4:0]        order;
  logic              pred, shift_bit, complement;
  logic              lock, inv, chk_valid, chk_err, loss, relock;
  logic [CNT_W-1:0]  bits, errs;
  logic [ESEC_W-1:0] esec;
  logic [SLIP_W-1:0] slips;
  logic              running, done;
  logic [63:0]       bits_x, errs_x;

  assign s_ready = 1'b1;
  assign start = reg_we && (reg_addr == 4'd0) && reg_wdata[0];
  assign stop  = reg_we && (reg_addr == 4'd0) && !reg_wdata[0];
  assign mask  = tap_mask(ctrl_q[5:2], ctrl_q[1], user_q);
  assign order = poly_order(ctrl_q[5:2], user_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; user_q <= '0; len_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0: ctrl_q <= reg_wdata[15:0];
        4'd1: user_q <= reg_wdata[LFSR_W-1:0];
        4'd2: len_q[31:0] <= reg_wdata;
        4'd3: len_q[63:32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  prbs_ref_gen u_ref (
    .clk(clk), .rst_n(rst_n), .shift_en(s_valid), .shift_bit(shift_bit),
    .complement(complement), .mask(mask), .pred(pred)
  );

  prbs_sync_fsm #(.WIN_LOG2(WIN_LOG2), .THR_W(THR_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .restart(start), .in_valid(s_valid), .in_bit(s_data),
    .pred(pred), .order(order), .thr(ctrl_q[6 +: THR_W]), .shift_bit(shift_bit),
    .complement(complement), .lock_o(lock), .inv_o(inv), .chk_valid(chk_valid),
    .chk_err(chk_err), .loss_o(loss), .relock_o(relock)
  );

  prbs_meas_counters #(.CNT_W(CNT_W), .ESEC_W(ESEC_W), .SLIP_W(SLIP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .len(len_q[CNT_W-1:0]),
    .chk_valid(chk_valid), .chk_err(chk_err), .sec_tick(sec_tick), .loss(loss),
    .relock(relock), .bits_o(bits), .errs_o(errs), .esec_o(esec), .slips_o(slips),
    .running_o(running), .done_o(done)
  );

  assign bits_x = 64'(bits);
  assign errs_x = 64'(errs);

  always_comb begin
    case (reg_addr)
      4'd0:  reg_rdata = {16'd0, ctrl_q};
      4'd1:  reg_rdata = 32'(user_q);
      4'd2:  reg_rdata = len_q[31:0];
      4'd3:  reg_rdata = len_q[63:32];
      4'd4:  reg_rdata = bits_x[31:0];
      4'd5:  reg_rdata = bits_x[63:32];
      4'd6:  reg_rdata = errs_x[31:0];
      4'd7:  reg_rdata = errs_x[63:32];
      4'd8:  reg_rdata = 32'(esec);
      4'd9:  reg_rdata = 32'(slips);
      4'd10: reg_rdata = {28'd0, running, done, inv, lock};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_prbs_rx_checker.sv
module sim_prbs_rx_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_data = 1'b0, sec_tick = 1'b0, reg_we = 1'b0;
  logic s_ready;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int nchk = 0, nerr = 0;
  logic [30:0] g_hist, g_mask;
  int g_n;
  logic [31:0] v;

  always #5 clk = ~clk;

  prbs_rx_checker u0 (.clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sec_tick(sec_tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd40(input logic [3:0] a, output longint d);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi);
    d = {hi[7:0], lo};
  endtask

  function automatic logic [30:0] tbit(input int k);
    return 31'(1) << (k - 1);
  endfunction

  // independent tap table from the requirement text
  task automatic set_poly(input int sel, input bit rev, input logic [30:0] user);
    int n, k;
    case (sel)
      0: begin n = 5; k = 3; end   1: begin n = 7; k = 6; end
      2: begin n = 9; k = 5; end   3: begin n = 11; k = 9; end
      4: begin n = 15; k = 14; end 5: begin n = 17; k = 14; end
      6: begin n = 19; k = 0; end  7: begin n = 20; k = 17; end
      8: begin n = 23; k = 18; end 9: begin n = 25; k = 22; end
      10: begin n = 31; k = 28; end
      default: begin n = 0; k = 0; end
    endcase
    if (sel == 11) begin
      g_mask = user; g_n = 0;
      for (int i = 0; i < 31; i++) if (user[i]) g_n = i + 1;
    end else if (sel == 6) begin
      g_n = 19;
      g_mask = rev ? (tbit(19) | tbit(1) | tbit(2) | tbit(5))
                   : (tbit(19) | tbit(18) | tbit(17) | tbit(14));
    end else begin
      g_n = n;
      g_mask = tbit(n) | tbit(rev ? n - k : k);
    end
    g_hist = '1;
  endtask

  function automatic logic next_bit();
    logic b;
    b = ^(g_hist & g_mask);
    g_hist = {g_hist[29:0], b};
    return b;
  endfunction

  task automatic send(input logic b);
    @(negedge clk); s_valid = 1'b1; s_data = b;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic send_seq(input int cnt, input bit inv);
    for (int i = 0; i < cnt; i++) send(next_bit() ^ inv);
  endtask

  task automatic send_err();
    send(~next_bit());
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic cfg(input int sel, input bit rev, input int thr, input longint len);
    wr(4'd2, len[31:0]); wr(4'd3, len[63:32]);
    wr(4'd0, {16'd0, 10'(thr), 4'(sel), rev, 1'b1});
  endtask

  initial begin
    #1_500_000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    longint b, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd10, v); check("R4 reset status", v, 0);
    rd40(4'd4, b); check("R1 reset bits", b, 0);
    check("R11 ready", s_ready, 1);
    wr(4'd1, 32'h30);

    // sweep: every sequence, both directions, plus user taps
    for (int sel = 0; sel < 12; sel++) begin
      for (int rev = 0; rev < 2; rev++) begin
        if (sel == 11 && rev == 1) continue;
        set_poly(sel, rev[0], 31'h30);
        cfg(sel, rev[0], 1023, 0);
        send_seq(3 * g_n - 1, 0);
        rd(4'd10, v); check("R4 not yet locked", v[0], 0);
        send_seq(1, 0);
        rd(4'd10, v); check("R4 locked at 3n", v[0], 1);
        send_seq(50, 0);
        rd40(4'd4, b); check(sel == 11 ? "R3 bits" : (rev ? "R2 bits" : "R1 bits"), b, 50);
        rd40(4'd6, e); check(sel == 11 ? "R3 errors" : (rev ? "R2 errors" : "R1 errors"), e, 0);
      end
    end

    // inverted stream
    set_poly(2, 0, 0); cfg(2, 0, 1023, 0);
    send_seq(27, 1);
    rd(4'd10, v); check("R5 lock", v[0], 1); check("R5 inverted flag", v[1], 1);
    send_seq(100, 1);
    rd40(4'd6, e); check("R5 errors", e, 0);
    rd40(4'd4, b); check("R5 bits", b, 100);

    // sparse errors counted
    set_poly(1, 0, 0); cfg(1, 0, 1023, 0);
    send_seq(21, 0);
    begin
      int exp_e = 0;
      for (int i = 0; i < 300; i++) begin
        if (i % 37 == 5) begin send_err(); exp_e++; end
        else send_seq(1, 0);
      end
      rd40(4'd6, e); check("R6 error count", e, exp_e);
      rd40(4'd4, b); check("R6 bit count", b, 300);
    end

    // resync on threshold, then slip
    set_poly(1, 0, 0); cfg(1, 0, 4, 0);
    send_seq(21, 0);
    rd(4'd9, v); check("R8 no slip yet", v, 0);
    for (int i = 0; i < 3; i++) begin send_seq(10, 0); send_err(); end
    rd(4'd10, v); check("R7 below threshold", v[0], 1);
    send_err();
    rd(4'd10, v); check("R7 loss at threshold", v[0], 0);
    rd40(4'd6, e); check("R6 errors before loss", e, 4);
    send_seq(20, 0);
    rd(4'd10, v); check("R4 relock pending", v[0], 0);
    send_seq(1, 0);
    rd(4'd10, v); check("R8 relocked", v[0], 1);
    rd(4'd9, v); check("R8 slip count", v, 1);

    // window expiry
    set_poly(1, 0, 0); cfg(1, 0, 2, 0);
    send_seq(21, 0);
    send_err(); send_seq(1100, 0); send_err();
    rd(4'd10, v); check("R7 window restart", v[0], 1);

    // errored seconds
    set_poly(1, 0, 0); cfg(1, 0, 1023, 0);
    send_seq(21, 0);
    tick(); rd(4'd8, v); check("R9 clean second", v, 0);
    send_seq(5, 0); send_err(); tick();
    rd(4'd8, v); check("R9 one errored second", v, 1);
    send_seq(20, 0); tick();
    rd(4'd8, v); check("R9 clean after", v, 1);
    send_err(); send_err(); tick();
    rd(4'd8, v); check("R9 two errors one second", v, 2);

    // test length
    set_poly(1, 0, 0); cfg(1, 0, 1023, 100);
    send_seq(21, 0); send_seq(99, 0);
    rd(4'd10, v); check("R10 not done", v[2], 0); check("R10 running", v[3], 1);
    send_seq(1, 0);
    rd(4'd10, v); check("R10 done", v[2], 1); check("R10 stopped", v[3], 0);
    send_seq(20, 0);
    rd40(4'd4, b); check("R10 bits held", b, 100);

    // valid low ignored
    set_poly(1, 0, 0); cfg(1, 0, 1023, 0);
    send_seq(21, 0); send_seq(10, 0);
    for (int i = 0; i < 50; i++) begin @(negedge clk); s_data = i[0]; end
    rd40(4'd4, b); check("R11 bits unchanged", b, 10);
    rd(4'd10, v); check("R11 still locked", v[0], 1);
    send_seq(30, 0);
    rd40(4'd6, e); check("R11 no errors after gap", e, 0);
    check("R11 ready", s_ready, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule